// File: doc/BRIEF.md
# 64-bit SEC-DED Check and Correct Unit

This block protects a 64-bit word with 8 check bits using an odd-weight-column parity-check matrix. It has two independent paths that are active in every cycle. The write path turns a data word into its 8 check bits and does no checking. The read path takes a data word and the check bits stored with it, recomputes the check bits and XORs them with the stored ones to form an 8-bit syndrome.

The read path then sorts the syndrome into one of five classes: clean, one data bit wrong, one check bit wrong, two bits wrong, or three or more bits wrong. A single wrong data bit is inverted on the corrected output. In every other class the data passes through unchanged. The block reports the syndrome, the position of a located bit and one flag per error class.

The logic is flow-through. A parameter adds one register stage on every output.

Top module: `secded_flow`

## Requirements
- R1: The column for data bit i is an 8-bit value. For i < 56 it is the i-th value, in ascending numeric order and counting from 0, that has exactly three set bits. For i >= 56 it is the (i-56)-th ascending value with exactly five set bits. Check bit j has the column with only bit j set. `wr_chk_o[j]` is the XOR of every bit of `wr_data_i` whose column has bit j set.
- R2: `syn_o` is `rd_chk_i` XOR the check bits regenerated from `rd_data_i` by the R1 rule. When it is zero, all four flags are low, `err_pos_o` is 0 and `rd_data_o` equals `rd_data_i`.
- R3: When the syndrome equals the column of data bit i, `single_data_o` is high, `err_pos_o` is i and `rd_data_o` is `rd_data_i` with bit i inverted.
- R4: When the syndrome has exactly one set bit j, `single_chk_o` is high, `err_pos_o` is j and `rd_data_o` equals `rd_data_i`.
- R5: When the syndrome is nonzero and has an even number of set bits, `double_o` is high, `err_pos_o` is 0 and the data is not changed.
- R6: When the syndrome has an odd number of set bits and matches no column, `multi_o` is high, `err_pos_o` is 0 and the data is not changed.
- R7: At most one of the four flags is high at any time.
- R8: With `OUT_REG`=1 (the default), every output shows the result for the inputs of the previous clock edge. While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_data_i | input | 64 | Word to be encoded for storage |
| wr_chk_o | output | 8 | Generated check bits |
| rd_data_i | input | 64 | Word read back from storage |
| rd_chk_i | input | 8 | Check bits read back with it |
| rd_data_o | output | 64 | Corrected read word |
| syn_o | output | 8 | Syndrome |
| err_pos_o | output | 7 | Located data bit (0..63) or check bit (0..7) |
| single_data_o | output | 1 | One data bit was wrong and has been corrected |
| single_chk_o | output | 1 | One check bit was wrong |
| double_o | output | 1 | Two bits were wrong |
| multi_o | output | 1 | Three or more bits were wrong |

## Verification
Encoding a write word and classifying a read word always happen in the same cycle. Both share the same register stage. The bench therefore drives a fresh random write word together with each read stimulus and checks both results on the same later clock. The read stimuli are clean words, every one of the 72 single flips, adjacent and random pairs, and random triples. An error on one path that bled into the other, or a lane that slipped by a cycle, would show up as a mismatch against the bench's own behavioural encoder and classifier.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int POS_W  = 7;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [CHK_W-1:0]  wchk;
    logic [CHK_W-1:0]  syn;
    logic [POS_W-1:0]  pos;
    logic              sd;
    logic              sc;
    logic              dbl;
    logic              multi;
  } out_t;

  // Weight-3 values first, then weight-5, both in ascending order
  function automatic logic [CHK_W-1:0] col_of(input int idx);
    logic [CHK_W-1:0] res;
    logic [CHK_W-1:0] vv;
    int n;
    res = '0;
    n   = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 0; v < (1 << CHK_W); v++) begin
        vv = v[CHK_W-1:0];
        if ($countones(vv) == w) begin
          if (n == idx) res = vv;
          n++;
        end
      end
    end
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] chk_mask(input int j);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    for (int i = 0; i < DATA_W; i++) begin
      c    = col_of(i);
      m[i] = c[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    localparam logic [DATA_W-1:0] Mask = chk_mask(j);
    assign chk_o[j] = ^(data_i & Mask);
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CHK_W-1:0]  syn_i,
  output logic [DATA_W-1:0] flip_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              sd_o,
  output logic              sc_o,
  output logic              dbl_o,
  output logic              multi_o
);
  logic [DATA_W-1:0] hit;
  logic              nz, odd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] Col = col_of(i);
    assign hit[i] = (syn_i == Col);
  end

  assign nz      = |syn_i;
  assign odd     = ^syn_i;
  assign sd_o    = |hit;
  assign sc_o    = ($countones(syn_i) == 1);
  assign dbl_o   = nz && !odd;
  assign multi_o = odd && !sd_o && !sc_o;
  assign flip_o  = hit;

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < DATA_W; i++)
      if (hit[i]) pos_o = POS_W'(i);
    if (sc_o)
      for (int j = 0; j < CHK_W; j++)
        if (syn_i[j]) pos_o = POS_W'(j);
  end
endmodule

// File: rtl/secded_flow.sv
module secded_flow
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [63:0]       wr_data_i,
  output logic [7:0]        wr_chk_o,
  input  logic [63:0]       rd_data_i,
  input  logic [7:0]        rd_chk_i,
  output logic [63:0]       rd_data_o,
  output logic [7:0]        syn_o,
  output logic [6:0]        err_pos_o,
  output logic              single_data_o,
  output logic              single_chk_o,
  output logic              double_o,
  output logic              multi_o
);
  logic [CHK_W-1:0]  wchk, rchk, syn;
  logic [DATA_W-1:0] flip;
  out_t              nxt, cur;

  secded_enc u_wenc (.data_i(wr_data_i), .chk_o(wchk));
  secded_enc u_renc (.data_i(rd_data_i), .chk_o(rchk));

  assign syn = rchk ^ rd_chk_i;

  secded_dec u_dec (
    .syn_i(syn), .flip_o(flip), .pos_o(nxt.pos),
    .sd_o(nxt.sd), .sc_o(nxt.sc), .dbl_o(nxt.dbl), .multi_o(nxt.multi)
  );

  assign nxt.data = rd_data_i ^ flip;
  assign nxt.wchk = wchk;
  assign nxt.syn  = syn;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) cur <= '0;
      else         cur <= nxt;
  end else begin : g_flow
    assign cur = nxt;
  end

  assign rd_data_o     = cur.data;
  assign wr_chk_o      = cur.wchk;
  assign syn_o         = cur.syn;
  assign err_pos_o     = cur.pos;
  assign single_data_o = cur.sd;
  assign single_chk_o  = cur.sc;
  assign double_o      = cur.dbl;
  assign multi_o       = cur.multi;

  // R7
  flag_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({single_data_o, single_chk_o, double_o, multi_o}));
  // R2
  clean_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_o == '0) |-> !(single_data_o || single_chk_o || double_o || multi_o));
  // R4
  chk_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_chk_o |-> ($countones(syn_o) == 1 && syn_o[err_pos_o[2:0]]));
  // R5
  dbl_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    double_o |-> (syn_o != '0 && !(^syn_o) && err_pos_o == '0));
  // R6
  multi_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> ((^syn_o) && $countones(syn_o) > 1 && err_pos_o == '0));
  // R3
  data_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_data_o |-> ($countones(syn_o) == 3 || $countones(syn_o) == 5));
endmodule

// File: tb/secded_flow_bench.sv
module secded_flow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wdata = '0, rdata = '0, rdo;
  logic [7:0]  rchk = '0, wchk, syn;
  logic [6:0]  pos;
  logic        sd, sc, dbl, mul;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  secded_flow u_secded_flow (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_data_i(wdata), .wr_chk_o(wchk),
    .rd_data_i(rdata), .rd_chk_i(rchk), .rd_data_o(rdo),
    .syn_o(syn), .err_pos_o(pos),
    .single_data_o(sd), .single_chk_o(sc), .double_o(dbl), .multi_o(mul)
  );

  logic [7:0] cols [64];

  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= cols[i];
    return c;
  endfunction

  // expected values for the stimulus applied one edge earlier
  bit          pend = 0;
  logic [63:0] e_data;
  logic [7:0]  e_wchk, e_syn;
  int          e_pos;
  logic [3:0]  e_flags; // {sd, sc, dbl, multi}
  string       e_req;

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    if (!pend) return;
    chk("R1", "wr_chk", 128'(wchk), 128'(e_wchk));
    chk(e_req, "syn", 128'(syn), 128'(e_syn));
    chk(e_req, "data", 128'(rdo), 128'(e_data));
    chk(e_req, "flags", 128'({sd, sc, dbl, mul}), 128'(e_flags));
    chk(e_req, "pos", 128'(pos), 128'(e_pos));
    if ($countones({sd, sc, dbl, mul}) > 1) chk("R7", "onehot", 128'({sd, sc, dbl, mul}), 128'(e_flags));
  endtask

  task automatic step(input logic [63:0] d, input logic [71:0] flips);
    logic [63:0] w;
    int k;
    @(negedge clk);
    compare();
    w = {$urandom, $urandom};
    wdata = w;
    rdata = d ^ flips[63:0];
    rchk  = enc(d) ^ flips[71:64];
    e_wchk = enc(w);
    e_syn  = enc(rdata) ^ rchk;
    e_data = rdata;
    e_pos  = 0;
    k = -1;
    for (int i = 0; i < 64; i++) if (cols[i] == e_syn) k = i;
    if (e_syn == 0) begin e_flags = 4'b0000; e_req = "R2"; end
    else if (k >= 0) begin
      e_flags = 4'b1000; e_req = "R3"; e_pos = k; e_data[k] = ~e_data[k];
    end else if ($countones(e_syn) == 1) begin
      e_flags = 4'b0100; e_req = "R4";
      for (int j = 0; j < 8; j++) if (e_syn[j]) e_pos = j;
    end else if ($countones(e_syn) % 2 == 0) begin e_flags = 4'b0010; e_req = "R5"; end
    else begin e_flags = 4'b0001; e_req = "R6"; end
    pend = 1;
  endtask

  function automatic logic [71:0] bitv(input int p);
    return 72'(1) << p;
  endfunction

  initial begin
    int n = 0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 0; v < 256; v++)
        if ($countones(v) == w && n < 64) begin cols[n] = v[7:0]; n++; end
  end

  initial begin
    logic [63:0] d;
    int a, b, c;
    repeat (3) @(negedge clk);
    // R8: reset clears every output
    chk("R8", "reset", 128'({wchk, rdo, syn, pos, sd, sc, dbl, mul}), 128'(0));
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) step({$urandom, $urandom}, '0);
    step('0, '0);
    step('1, '0);
    for (int p = 0; p < 72; p++) step({$urandom, $urandom}, bitv(p));
    for (int p = 0; p < 71; p++) step({$urandom, $urandom}, bitv(p) | bitv(p + 1));
    for (int i = 0; i < 150; i++) begin
      a = $urandom_range(71); b = (a + 1 + $urandom_range(70)) % 72;
      step({$urandom, $urandom}, bitv(a) | bitv(b));
    end
    for (int i = 0; i < 300; i++) begin
      a = $urandom_range(71); b = (a + 1 + $urandom_range(69)) % 72;
      c = a;
      while (c == a || c == b) c = $urandom_range(71);
      d = {$urandom, $urandom};
      step(d, bitv(a) | bitv(b) | bitv(c));
    end
    @(negedge clk);
    compare();
    pend = 0;
    // R8: reset forces outputs back to zero
    rst_n = 1'b0;
    #1;
    chk("R8", "reset again", 128'({wchk, rdo, syn, pos, sd, sc, dbl, mul}), 128'(0));
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule